// File: doc/BRIEF.md
# Add-and-Rotate Sequential Multiplier

This block multiplies two unsigned N-bit operands over N clock cycles. It loads the multiplicand once and never changes it afterwards. The 2N-bit product register starts at zero. Each step reads one multiplier bit, starting with bit 0. When that bit is 1, a ripple add-or-pass network adds the multiplicand into an (N+1)-bit window of the product register. The multiplicand's bit 0 lines up with product bit N-1, and the carry out lands in the top product bit.

After the add, the whole product register rotates right by one position. The rotator is two layers of disjoint bit swaps, not a shift chain. The final step adds only and does not rotate. Because of this, the product is already aligned when `done_o` pulses.

A client raises `start_i` for one cycle with both operands while the block is idle. It then waits for the one-cycle `done_o` pulse and reads `prod_o`. During the whole operation, `mcand_o` shows the multiplicand the block is holding.

Top module: `addrot_mul`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `prod_o` are all zero.
- R2: In the cycle where `done_o` is 1, `prod_o` equals the unsigned product of the operands accepted with the last start.
- R3: `mcand_o` never changes while `busy_o` is 1, and at `done_o` it still equals the accepted multiplicand.
- R4: A start is accepted when `start_i` is 1 and `busy_o` is 0. After that, `busy_o` stays 1 for exactly N cycles. `done_o` is 1 in the (N+1)-th cycle after the accepting edge, and `busy_o` is then 0.
- R5: `done_o` is high for a single cycle each time.
- R6: While `busy_o` is 1, `start_i` and the operand inputs are ignored, and the running operation finishes with its original operands.
- R7: The rotator maps every width W from 2 upwards to `{x[0], x[W-1:1]}`. It does this using two swap layers: first pairs (k, W-1-k), then pairs (k, W-2-k).
- R8: A zero operand gives a zero product. Two all-ones operands give (2^N-1)^2, which requires the add carry to land in the top product bit.
- R9: One cycle after a start is accepted, `busy_o` is 1 and `prod_o` is zero, whatever the previous result was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiply; honoured only when idle |
| mcand_i | input | N | Multiplicand operand |
| mplier_i | input | N | Multiplier operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: product valid |
| prod_o | output | 2N | Product register |
| mcand_o | output | N | Held multiplicand, unchanged by the operation |

## Verification
The bench builds the multiplier twice. The N=4 copy is driven with every one of the 256 operand pairs, so every carry pattern through the narrow window is reached. The N=8 copy gets seeded random pairs, plus zero and all-ones corners and starts issued while busy. For the rotator alone, the bench builds every width from 2 to 16. The odd widths reach the unpaired middle bit in each swap layer, and W=2 reaches the degenerate second layer.

// File: rtl/addrot_pkg.sv
package addrot_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/addrot_addpass.sv
// Conditional (N+1)-bit window accumulate: when en_i is set the window's low N
// bits get the addend and the carry out replaces the window's top bit.
module addrot_addpass #(
    parameter int N = 8
) (
    input  logic         en_i,
    input  logic [N:0]   acc_i,
    input  logic [N-1:0] addend_i,
    output logic [N:0]   acc_o
);
    logic [N:0]   carry;
    logic [N-1:0] sum;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic diff;
        assign diff       = acc_i[i] ^ addend_i[i];
        assign sum[i]     = diff ^ carry[i];
        // propagate when bits differ, otherwise the shared bit value is the carry
        assign carry[i+1] = diff ? carry[i] : acc_i[i];
    end

    assign acc_o = en_i ? {carry[N], sum} : acc_i;
endmodule

// File: rtl/addrot_ror.sv
// Rotate right by one as two layers of disjoint swaps:
// layer 1 reverses all W bits, layer 2 reverses the low W-1 bits.
module addrot_ror #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int H1 = W / 2;
    localparam int H2 = (W - 1) / 2;

    logic [W-1:0] mid;

    for (genvar k = 0; k < H1; k++) begin : g_l1
        assign mid[k]       = din[W-1-k];
        assign mid[W-1-k]   = din[k];
    end
    if (W % 2 == 1) begin : g_l1_mid
        assign mid[H1] = din[H1];
    end

    for (genvar k = 0; k < H2; k++) begin : g_l2
        assign dout[k]      = mid[W-2-k];
        assign dout[W-2-k]  = mid[k];
    end
    if ((W - 1) % 2 == 1) begin : g_l2_mid
        assign dout[(W-2)/2] = mid[(W-2)/2];
    end
    assign dout[W-1] = mid[W-1];
endmodule

// File: rtl/addrot_mul.sv
module addrot_mul
    import addrot_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*N-1:0] prod_o,
    output logic [N-1:0]   mcand_o
);
    localparam int PW = 2 * N;
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    typedef struct packed {
        phase_e        ph;
        logic          done;
        logic [CW-1:0] m;
        logic [N-1:0]  a;
        logic [N-1:0]  b;
        logic [PW-1:0] p;
    } st_t;

    st_t s_d, s_q;

    logic          add_en;
    logic [N:0]    win_in;
    logic [N:0]    win_out;
    logic [PW-1:0] p_add;
    logic [PW-1:0] p_rot;

    assign add_en = s_q.a[s_q.m];
    assign win_in = s_q.p[PW-1:N-1];

    addrot_addpass #(.N(N)) u_add (
        .en_i     (add_en),
        .acc_i    (win_in),
        .addend_i (s_q.b),
        .acc_o    (win_out)
    );

    assign p_add = {win_out, s_q.p[N-2:0]};

    addrot_ror #(.W(PW)) u_ror (
        .din  (p_add),
        .dout (p_rot)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.ph = PH_RUN;
                    s_d.m  = '0;
                    s_d.a  = mplier_i;
                    s_d.b  = mcand_i;
                    s_d.p  = '0;
                end
            end
            default: begin
                if (s_q.m == LAST) begin
                    s_d.p    = p_add;
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.p = p_rot;
                    s_d.m = s_q.m + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o  = (s_q.ph == PH_RUN);
    assign done_o  = s_q.done;
    assign prod_o  = s_q.p;
    assign mcand_o = s_q.b;
endmodule

// File: rtl/addrot_mul_chk.sv
module addrot_mul_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [N-1:0]   mplier_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*N-1:0] prod_o,
    input logic [N-1:0]   mcand_o
);
    int unsigned  busy_cnt;
    logic [N-1:0] a_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= 0;
            a_cap    <= '0;
        end else if (start_i && !busy_o) begin
            busy_cnt <= 0;
            a_cap    <= mplier_i;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 1;
        end
    end

    p_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> prod_o == ((2*N)'(a_cap) * (2*N)'(mcand_o)));

    p_hold_mcand_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(mcand_o));

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt == N && !busy_o));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && prod_o == '0));
endmodule

bind addrot_mul addrot_mul_chk #(.N(N)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .mplier_i (mplier_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .prod_o   (prod_o),
    .mcand_o  (mcand_o)
);

// File: tb/addrot_mul_tb_top.sv
`timescale 1ns/1ps
module addrot_mul_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;

    // N=8 instance
    logic        st8 = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic        busy8, done8;
    logic [15:0] p8;
    logic [7:0]  m8;
    addrot_mul #(.N(8)) dut_i (.clk(clk), .rst_n(rst_n), .start_i(st8), .mcand_i(b8),
        .mplier_i(a8), .busy_o(busy8), .done_o(done8), .prod_o(p8), .mcand_o(m8));

    // N=4 instance
    logic       st4 = 1'b0;
    logic [3:0] a4 = '0, b4 = '0;
    logic       busy4, done4;
    logic [7:0] p4;
    logic [3:0] m4;
    addrot_mul #(.N(4)) dut4_i (.clk(clk), .rst_n(rst_n), .start_i(st4), .mcand_i(b4),
        .mplier_i(a4), .busy_o(busy4), .done_o(done4), .prod_o(p4), .mcand_o(m4));

    // rotators for widths 2..16
    logic [15:0] rx = '0;
    logic [15:0] rot_out [2:16];
    for (genvar g = 2; g <= 16; g++) begin : g_rot
        logic [g-1:0] y;
        addrot_ror #(.W(g)) u_r (.din(rx[g-1:0]), .dout(y));
        assign rot_out[g] = 16'(y);
    end

    function automatic logic [15:0] ref_ror(input logic [15:0] x, input int w);
        logic [15:0] mask;
        mask = (16'h1 << w) - 16'h1;
        if (w == 16) mask = 16'hFFFF;
        return ((x & mask) >> 1) | (16'(x[0]) << (w - 1));
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run8(input logic [7:0] a, input logic [7:0] b, input bit poke);
        int cnt;
        st8 = 1'b1; a8 = a; b8 = b;
        @(posedge clk); #1;
        st8 = 1'b0;
        chk(busy8 && p8 == 16'h0, "R9 clear on start", longint'(p8), 0);
        if (poke) begin
            st8 = 1'b1; a8 = ~a; b8 = ~b;     // R6: must be ignored
        end
        cnt = 1;
        while (!done8 && cnt < 40) begin
            @(posedge clk); #1;
            st8 = 1'b0;
            cnt++;
        end
        chk(cnt == 9 && !busy8, "R4 latency", cnt, 9);
        chk(p8 == 16'(a) * 16'(b), poke ? "R6 start ignored, R2 product" : "R2 product",
            longint'(p8), longint'(16'(a) * 16'(b)));
        chk(m8 == b, "R3 multiplicand kept", longint'(m8), longint'(b));
        @(posedge clk); #1;
        chk(!done8, "R5 done pulse", longint'(done8), 0);
    endtask

    task automatic run4(input logic [3:0] a, input logic [3:0] b);
        int cnt;
        st4 = 1'b1; a4 = a; b4 = b;
        @(posedge clk); #1;
        st4 = 1'b0;
        cnt = 1;
        while (!done4 && cnt < 40) begin
            @(posedge clk); #1;
            cnt++;
        end
        chk(cnt == 5, "R4 latency n4", cnt, 5);
        chk(p4 == 8'(a) * 8'(b), "R2 product n4", longint'(p4), longint'(8'(a) * 8'(b)));
        chk(m4 == b, "R3 multiplicand n4", longint'(m4), longint'(b));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] r;
        void'($urandom(32'd1234));
        #1;
        chk(!busy8 && !done8 && p8 == 0, "R1 reset n8", longint'(p8), 0);
        chk(!busy4 && !done4 && p4 == 0, "R1 reset n4", longint'(p4), 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R7 rotator, all widths
        for (int t = 0; t < 40; t++) begin
            rx = (t == 0) ? 16'h0001 : (t == 1) ? 16'h8000 : 16'($urandom);
            #1;
            for (int w = 2; w <= 16; w++) begin
                r = ref_ror(rx, w);
                chk(rot_out[w] == r, "R7 rotator", longint'(rot_out[w]), longint'(r));
            end
        end

        // R8 corners
        run8(8'h00, 8'hA5, 1'b0);
        run8(8'h5A, 8'h00, 1'b0);
        run8(8'hFF, 8'hFF, 1'b0);
        run8(8'h80, 8'hFF, 1'b0);
        run4(4'hF, 4'hF);
        chk(p4 == 8'hE1, "R8 all-ones n4", longint'(p4), 'hE1);

        // exhaustive N=4
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                run4(4'(a), 4'(b));

        // random N=8, some with starts while busy
        for (int t = 0; t < 300; t++)
            run8(8'($urandom), 8'($urandom), (t % 5) == 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule